// File: doc/BRIEF.md
# Serial DAC Command Interface

This block is the command front end of a converter channel. A host sends 24-bit frames over a four-wire SPI-style link: a serial clock, an active-low frame select, data in and data out. The block oversamples the link with its own system clock. A frame is taken into account only when frame select returns high, and only when that frame saw exactly 24 serial clock rising edges. Frame bits 19 to 16 hold a 4-bit command code and bits 15 to 0 hold a data field. Bits 23 to 21 are ignored. Bit 20 must be zero.

The block holds two code registers. The staging register takes new values without touching the output. The output register drives the parallel `dac_code` port. Because of this pair, a code can be written first and applied later. The block also holds a 16-bit control register, whose contents it only stores and returns. Readback commands queue a 24-bit reply, and the reply is shifted out on the data-out line during the next frame. When no reply is queued and daisy-chain mode is on, data out repeats data in delayed by 24 bits, so several devices can share one select line. The link is a plain serial shift path, so it has no back-pressure. The host paces all traffic through the serial clock. A parameter selects 16-bit or 12-bit code resolution.

Top module: `dac_cmd_if`

## Requirements
- R1: A frame is acted on only at the rising edge of `cs_n`, and only if exactly 24 `sclk` rising edges arrived while `cs_n` was low. Frames with 23 or 25 edges change no register.
- R2: A 24-edge frame whose bit 20 is 1 is discarded and changes no register.
- R3: Code 0x1 loads the staging register from the data field, and `dac_code` keeps its value.
- R4: Code 0x2 copies the staging register into the output register, and `dac_code` takes that value.
- R5: Code 0x3 writes the data field into both registers, and `dac_code` takes the new value.
- R6: Code 0x4 writes the 16-bit control register. A later control readback returns the written value.
- R7: Codes 0xA, 0xB and 0xC request readback of the staging register, the output register and the control register. During the next frame, `sdo` presents MSB first, one bit before each `sclk` rise, the word {4'b0000, code, register value in bits 15:0}.
- R8: While daisy-chain is enabled and no reply is queued, the bit on `sdo` before the k-th rise of a frame equals the `sdi` bit shifted in 24 rises earlier.
- R9: Code 0x9 disables daisy-chain. From then on `sdo` is 0 in every frame that carries no reply.
- R10: Code 0x7 clears the staging and output registers. The control register and daisy-chain mode are kept.
- R11: Code 0xF clears all three registers and re-enables daisy-chain. Hardware reset leaves the same state: `dac_code` is 0 and daisy-chain is on.
- R12: Codes 0x0, 0x5, 0x6, 0x8, 0xD and 0xE leave every register and the daisy-chain mode unchanged.
- R13: With RES=12, the code is taken from frame bits 15:4, bits 3:0 are ignored, and a readback of either code register returns the code in bits 15:4 with zeros in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than four times the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data in is taken on its rising edge |
| cs_n | input | 1 | Active-low frame select; its rising edge closes a frame |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out: readback reply or delayed data in |
| dac_code | output | RES | Output register contents |

## Verification
A corrupted staging or output register appears on `dac_code` about four system clocks after the next update or write-through frame closes. The same corruption shows earlier, in the next frame, when a readback is requested. A wrong daisy-chain flag or a wrong reply queue shows on the first `sdo` bit of the next frame, because that bit is either 0, the queued reply, or the data from the previous frame. A mistake in the edge counter or in the bit-20 check shows as a register change that a discarded frame should not have caused.

// File: rtl/dac_cmd_pkg.sv
`timescale 1ns/1ps
package dac_cmd_pkg;
  localparam int FRAME_W  = 24;
  localparam int DATA_W   = 16;
  localparam int CMD_W    = 4;
  localparam int ZERO_BIT = 20;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP       = 4'h0,
    CMD_LOAD      = 4'h1,
    CMD_APPLY     = 4'h2,
    CMD_LOAD_APPLY = 4'h3,
    CMD_CTRL      = 4'h4,
    CMD_CLR_CODE  = 4'h7,
    CMD_DAISY_OFF = 4'h9,
    CMD_RD_STAGE  = 4'hA,
    CMD_RD_OUT    = 4'hB,
    CMD_RD_CTRL   = 4'hC,
    CMD_CLR_ALL   = 4'hF
  } cmd_e;
endpackage

// File: rtl/dac_frame_rx.sv
`timescale 1ns/1ps
module dac_frame_rx
  import dac_cmd_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              shift_en,
  output logic              cs_fall,
  output logic              cs_rise,
  output logic              sdi_q,
  output logic              frm_ok,
  output logic [CMD_W-1:0]  frm_cmd,
  output logic [DATA_W-1:0] frm_data
);
  localparam int KEEP_W = ZERO_BIT + 1;
  localparam int CNT_W  = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [SYNC:0]     sclk_p, cs_p;
  logic [SYNC-1:0]   sdi_p;
  logic [CNT_W-1:0]  edge_cnt;
  logic [KEEP_W-1:0] shreg;
  logic              sel, rise;

  // input synchronisers; sdi delayed to line up with sclk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      sdi_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC-1:0], sclk};
      cs_p   <= {cs_p[SYNC-1:0], cs_n};
      sdi_p  <= {sdi_p[SYNC-2:0], sdi};
    end
  end

  assign sel      = ~cs_p[SYNC-1];
  assign rise     = sclk_p[SYNC-1] & ~sclk_p[SYNC];
  assign cs_fall  = ~cs_p[SYNC-1] & cs_p[SYNC];
  assign cs_rise  = cs_p[SYNC-1] & ~cs_p[SYNC];
  assign shift_en = rise & sel;
  assign sdi_q    = sdi_p[SYNC-1];

  // edge counter saturates one past a full frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      shreg    <= '0;
    end else if (cs_fall) begin
      edge_cnt <= '0;
    end else if (shift_en) begin
      shreg <= {shreg[KEEP_W-2:0], sdi_q};
      if (edge_cnt != CNT_SAT) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_ok   <= 1'b0;
      frm_cmd  <= '0;
      frm_data <= '0;
    end else begin
      frm_ok <= cs_rise && (edge_cnt == CNT_FULL) && !shreg[ZERO_BIT];
      if (cs_rise) begin
        frm_cmd  <= shreg[DATA_W +: CMD_W];
        frm_data <= shreg[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dac_cmd_regs.sv
`timescale 1ns/1ps
module dac_cmd_regs
  import dac_cmd_pkg::*;
#(
  parameter int RES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_ok,
  input  logic [CMD_W-1:0]   frm_cmd,
  input  logic [DATA_W-1:0]  frm_data,
  output logic [RES-1:0]     dac_code,
  output logic               daisy_en,
  output logic               rb_set,
  output logic [FRAME_W-1:0] rb_word
);
  localparam int PAD = DATA_W - RES;
  localparam int TOP = FRAME_W - DATA_W - CMD_W;

  cmd_e              cmd;
  logic [RES-1:0]    stage_q, out_q, wr_val;
  logic [DATA_W-1:0] ctrl_q, stage_al, out_al, rb_sel;
  logic              is_rb;

  assign cmd = cmd_e'(frm_cmd);

  // resolution variant: where the code sits inside the 16-bit field
  generate
    if (PAD == 0) begin : g_full
      assign wr_val   = frm_data;
      assign stage_al = stage_q;
      assign out_al   = out_q;
    end else begin : g_part
      assign wr_val   = frm_data[DATA_W-1 -: RES];
      assign stage_al = {stage_q, {PAD{1'b0}}};
      assign out_al   = {out_q, {PAD{1'b0}}};
    end
  endgenerate

  always_comb begin
    is_rb  = 1'b0;
    rb_sel = ctrl_q;
    case (cmd)
      CMD_RD_STAGE: begin is_rb = 1'b1; rb_sel = stage_al; end
      CMD_RD_OUT:   begin is_rb = 1'b1; rb_sel = out_al;   end
      CMD_RD_CTRL:  begin is_rb = 1'b1; rb_sel = ctrl_q;   end
      default:      ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      out_q    <= '0;
      ctrl_q   <= '0;
      daisy_en <= 1'b1;
      rb_set   <= 1'b0;
      rb_word  <= '0;
    end else begin
      rb_set <= frm_ok & is_rb;
      if (frm_ok && is_rb) rb_word <= {{TOP{1'b0}}, frm_cmd, rb_sel};
      if (frm_ok) begin
        case (cmd)
          CMD_LOAD:       stage_q <= wr_val;
          CMD_APPLY:      out_q   <= stage_q;
          CMD_LOAD_APPLY: begin stage_q <= wr_val; out_q <= wr_val; end
          CMD_CTRL:       ctrl_q  <= frm_data;
          CMD_CLR_CODE:   begin stage_q <= '0; out_q <= '0; end
          CMD_DAISY_OFF:  daisy_en <= 1'b0;
          CMD_CLR_ALL: begin
            stage_q  <= '0;
            out_q    <= '0;
            ctrl_q   <= '0;
            daisy_en <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign dac_code = out_q;
endmodule

// File: rtl/dac_sdo_tx.sv
`timescale 1ns/1ps
module dac_sdo_tx
  import dac_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               cs_fall,
  input  logic               cs_rise,
  input  logic               sdi_q,
  input  logic               daisy_en,
  input  logic               rb_set,
  input  logic [FRAME_W-1:0] rb_word,
  output logic               sdo
);
  logic [FRAME_W-1:0] os, hold;
  logic               pend, rb_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os     <= '0;
      hold   <= '0;
      pend   <= 1'b0;
      rb_act <= 1'b0;
      sdo    <= 1'b0;
    end else begin
      if (rb_set) begin
        pend <= 1'b1;
        hold <= rb_word;
      end else if (cs_fall) begin
        pend <= 1'b0;
      end
      if (cs_fall) rb_act <= pend;
      else if (cs_rise) rb_act <= 1'b0;
      if (cs_fall && pend) os <= hold;
      else if (shift_en) os <= {os[FRAME_W-2:0], sdi_q};
      sdo <= (daisy_en | rb_act) & os[FRAME_W-1];
    end
  end
endmodule

// File: rtl/dac_cmd_if.sv
`timescale 1ns/1ps
module dac_cmd_if
  import dac_cmd_pkg::*;
#(
  parameter int RES  = 16,
  parameter int SYNC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk,
  input  logic           cs_n,
  input  logic           sdi,
  output logic           sdo,
  output logic [RES-1:0] dac_code
);
  logic               shift_en, cs_fall, cs_rise, sdi_q, frm_ok;
  logic [CMD_W-1:0]   frm_cmd;
  logic [DATA_W-1:0]  frm_data;
  logic               daisy_en, rb_set;
  logic [FRAME_W-1:0] rb_word;

  dac_frame_rx #(.SYNC(SYNC)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .shift_en(shift_en), .cs_fall(cs_fall), .cs_rise(cs_rise), .sdi_q(sdi_q),
    .frm_ok(frm_ok), .frm_cmd(frm_cmd), .frm_data(frm_data)
  );

  dac_cmd_regs #(.RES(RES)) u_regs (
    .clk(clk), .rst_n(rst_n), .frm_ok(frm_ok), .frm_cmd(frm_cmd),
    .frm_data(frm_data), .dac_code(dac_code), .daisy_en(daisy_en),
    .rb_set(rb_set), .rb_word(rb_word)
  );

  dac_sdo_tx u_tx (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sdi_q(sdi_q), .daisy_en(daisy_en), .rb_set(rb_set),
    .rb_word(rb_word), .sdo(sdo)
  );
endmodule

// File: rtl/dac_cmd_chk.sv
`timescale 1ns/1ps
module dac_cmd_chk
  import dac_cmd_pkg::*;
#(
  parameter int RES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_ok,
  input logic [CMD_W-1:0]  frm_cmd,
  input logic [DATA_W-1:0] frm_data,
  input logic [RES-1:0]    dac_code,
  input logic              daisy_en
);
  // R1
  code_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> $past(frm_ok));

  // R3
  load_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_ok && frm_cmd == 4'h1) |=> $stable(dac_code));

  // R5
  load_apply_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_ok && frm_cmd == 4'h3) |=> (dac_code == $past(frm_data[DATA_W-1 -: RES])));

  // R9
  daisy_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_ok && frm_cmd == 4'h9) |=> !daisy_en);

  // R10
  clear_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_ok && frm_cmd == 4'h7) |=> (dac_code == '0));

  // R11
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_ok && frm_cmd == 4'hF) |=> (dac_code == '0 && daisy_en));
endmodule

bind dac_cmd_if dac_cmd_chk #(.RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_ok(frm_ok), .frm_cmd(frm_cmd),
  .frm_data(frm_data), .dac_code(dac_code), .daisy_en(daisy_en)
);

// File: tb/sim_dac_cmd_if.sv
`timescale 1ns/1ps
module sim_dac_cmd_if;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo0, sdo1;
  logic [15:0] code0;
  logic [11:0] code1;

  always #2 clk = ~clk;

  dac_cmd_if #(.RES(16)) u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .sdi(sdi), .sdo(sdo0), .dac_code(code0));
  dac_cmd_if #(.RES(12)) u1 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .sdi(sdi), .sdo(sdo1), .dac_code(code1));

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state, all held as 16-bit fields
  logic [15:0] m_stage = 0, m_out = 0, m_ctrl = 0;
  logic        m_daisy = 1, m_pend = 0;
  logic [23:0] m_hist = 0, m_rb0 = 0, m_rb1 = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string tag_of(input logic [23:0] w, input int nb);
    if (nb != 24) return "R1";
    if (w[20]) return "R2";
    case (w[19:16])
      4'h1: return "R3";
      4'h2: return "R4";
      4'h3: return "R5";
      4'h4: return "R6";
      4'h7: return "R10";
      4'h9: return "R9";
      4'hA, 4'hB, 4'hC: return "R7";
      4'hF: return "R11";
      default: return "R12";
    endcase
  endfunction

  // builds the reply a readback code should produce, per resolution
  function automatic logic [23:0] reply(input logic [3:0] c, input bit twelve);
    logic [15:0] v;
    case (c)
      4'hA: v = m_stage;
      4'hB: v = m_out;
      default: v = m_ctrl;
    endcase
    if (twelve && c != 4'hC) v[3:0] = 4'h0;
    return {4'h0, c, v};
  endfunction

  task automatic do_frame(input logic [23:0] w, input int nb);
    logic [23:0] o0, o1, exp0, exp1;
    bit rb_now;
    string t;
    o0 = 0; o1 = 0;
    rb_now = m_pend;
    m_pend = 0;
    if (rb_now) begin
      exp0 = m_rb0; exp1 = m_rb1; m_hist = m_rb0;
    end else begin
      exp0 = m_daisy ? m_hist : 24'h0; exp1 = exp0;
    end
    cs_n = 1'b0;
    wait_n(8);
    for (int i = 0; i < nb; i++) begin
      sdi = (i < 24) ? w[23-i] : 1'b0;
      wait_n(4);
      if (i < 24) begin o0[23-i] = sdo0; o1[23-i] = sdo1; end
      m_hist = {m_hist[22:0], sdi};
      sclk = 1'b1;
      wait_n(4);
      sclk = 1'b0;
    end
    wait_n(4);
    cs_n = 1'b1;
    if (nb >= 24) begin
      t = rb_now ? ((m_rb0[19:16] == 4'hC) ? "R6" : "R7") : (m_daisy ? "R8" : "R9");
      chk(t, o0, exp0);
      chk("R13", o1, exp1);
    end
    if (nb == 24 && !w[20]) begin
      case (w[19:16])
        4'h1: m_stage = w[15:0];
        4'h2: m_out = m_stage;
        4'h3: begin m_stage = w[15:0]; m_out = w[15:0]; end
        4'h4: m_ctrl = w[15:0];
        4'h7: begin m_stage = 0; m_out = 0; end
        4'h9: m_daisy = 0;
        4'hA, 4'hB, 4'hC: begin
          m_pend = 1; m_rb0 = reply(w[19:16], 0); m_rb1 = reply(w[19:16], 1);
        end
        4'hF: begin m_stage = 0; m_out = 0; m_ctrl = 0; m_daisy = 1; end
        default: ;
      endcase
    end
    wait_n(14);
    t = tag_of(w, nb);
    chk(t, {16'h0, code0}, {16'h0, m_out});
    chk("R13", {20'h0, code1}, {20'h0, m_out[15:4]});
  endtask

  function automatic logic [23:0] fr(input logic [3:0] c, input logic [15:0] d);
    return {4'h0, c, d};
  endfunction

  initial begin
    #600000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] w;
    int nb;
    void'($urandom(32'd4711));
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    // R11 reset state
    chk("R11", {16'h0, code0}, 32'h0);
    chk("R11", {31'h0, sdo0}, 32'h0);
    chk("R13", {20'h0, code1}, 32'h0);

    do_frame(fr(4'h1, 16'hA5C3), 24);            // R3
    do_frame(fr(4'h2, 16'h0000), 24);            // R4
    do_frame(fr(4'h3, 16'h1234), 24);            // R5
    do_frame({3'b101, 1'b0, 4'h3, 16'h7E0F}, 24); // don't-care top bits
    do_frame(fr(4'h4, 16'hBEEF), 24);            // R6
    do_frame(fr(4'hC, 16'h0000), 24);            // R7 ctrl readback queued
    do_frame(fr(4'hA, 16'hFFFF), 24);            // R6 reply out, R7 queued
    do_frame(fr(4'hB, 16'h0000), 24);
    do_frame(fr(4'h0, 16'h0000), 24);
    do_frame(fr(4'h3, 16'h5555), 23);            // R1 short
    do_frame(fr(4'h3, 16'h6666), 25);            // R1 long
    do_frame({4'b0001, 4'h3, 16'h7777}, 24);     // R2 bit 20 set
    do_frame(fr(4'h5, 16'h1111), 24);            // R12 no-ops
    do_frame(fr(4'h6, 16'h2222), 24);
    do_frame(fr(4'h8, 16'h3333), 24);
    do_frame(fr(4'hD, 16'h4444), 24);
    do_frame(fr(4'hE, 16'h5555), 24);
    do_frame(fr(4'hA, 16'h0000), 24);
    do_frame(fr(4'h1, 16'h9ABF), 24);            // R13 low nibble dropped
    do_frame(fr(4'hA, 16'h0000), 24);
    do_frame(fr(4'h7, 16'hFFFF), 24);            // R10
    do_frame(fr(4'hC, 16'h0000), 24);            // ctrl kept
    do_frame(fr(4'h9, 16'h0000), 24);            // R9
    do_frame(fr(4'h3, 16'hC001), 24);
    do_frame(fr(4'hB, 16'h0000), 24);
    do_frame(fr(4'h0, 16'hFFFF), 24);
    do_frame(fr(4'h0, 16'hFFFF), 24);            // R9 sdo stays low
    do_frame(fr(4'hF, 16'h0000), 24);            // R11
    do_frame(fr(4'h0, 16'h0F0F), 24);
    do_frame(fr(4'hC, 16'h0000), 24);            // R8 daisy back on
    do_frame(fr(4'h0, 16'h0000), 24);

    for (int k = 0; k < 90; k++) begin
      w = $urandom;
      w[20] = ($urandom % 10 == 0);
      nb = 24;
      if ($urandom % 10 == 0) nb = ($urandom % 2) ? 23 : 25;
      do_frame(w, nb);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule